// File: doc/BRIEF.md
# Masked Dual Alarm Comparator

This block watches the running calendar time and raises an alarm whenever it matches one of two programmable alarm settings. Each alarm setting has one byte each for seconds, minutes, hour, date, month and weekday. Each byte uses the same BCD layout as the matching time byte, except that bit 7 turns comparison of that field on. The year is never compared. Comparison happens only on the cycle that carries the seconds tick. A matching tick sets the alarm's flag in a status byte. It can also produce a one-cycle interrupt pulse, under the control of an interrupt control byte.

Software clears the flags through a status read, which the surrounding logic marks with a start strobe and an end strobe. Only the flags that were already set when the read started are cleared. An alarm that fires while the read is in progress is kept, so it can be seen by the next read.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset both flags are 0, the interrupt output is 0, every alarm byte and the interrupt control byte are 0, so nothing matches.
- R2: An alarm matches only on a cycle with `tick` high. On such a cycle, every field whose enable bit (bit 7) is 1 must have its bits 6:0 equal to bits 6:0 of the live time byte. The flag is visible in `status` one clock edge after that tick.
- R3: Fields whose enable bit is 0 are ignored in the comparison, and no year field exists.
- R4: An alarm whose six enable bits are all 0 never matches.
- R5: `status` bit 5 holds the alarm 0 flag and bit 6 holds the alarm 1 flag. All other status bits read 0.
- R6: The `st_rd_end` strobe clears only the flags that were set on the cycle `st_rd_start` was high.
- R7: A flag raised after `st_rd_start` stays set through the following `st_rd_end`.
- R8: Interrupt control byte: bit 6 enables interrupts for alarm 1 and bit 5 enables them for alarm 0. A match of an alarm whose enable bit is 0 never pulses `irq`.
- R9: Interrupt control bit 7 sets the mode. When it is 0, `irq` pulses for one cycle only when the flag goes from clear to set. When it is 1, `irq` pulses on every match, even if the flag is still set. The pulse comes one edge after the tick.
- R10: Write address map. Bit 3 selects the alarm set. Bits 2:0 select the field: 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 6 weekday. Offsets 5 and 7 are reserved, and writes to them are ignored. Address 0x10 is the interrupt control byte.
- R11: The two alarms are independent. A match of one never sets the other's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Seconds tick; time fields valid for compare |
| tm_sec | input | 8 | Live BCD seconds |
| tm_min | input | 8 | Live BCD minutes |
| tm_hour | input | 8 | Live BCD hour |
| tm_date | input | 8 | Live BCD date |
| tm_month | input | 8 | Live BCD month |
| tm_wday | input | 8 | Live weekday |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| st_rd_start | input | 1 | Status read begins |
| st_rd_end | input | 1 | Status read last data bit done |
| status | output | 8 | Status byte with alarm flags |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
Flags and the interrupt pulse come from the same register stage. Both are due at the first rising edge that samples `tick`, so the bench drops the tick on the next falling edge and checks there. A clear takes effect at the edge that samples `st_rd_end`, and it is checked one falling edge later. Register writes take effect one edge after `wr_en`. The bench drives each stimulus for exactly one clock period from a falling edge, so no check sits on an edge where an output is still changing.

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
  parameter int NUM_ALARMS = 2,
  parameter int FIELDS     = 8,
  parameter int AW         = 5,
  parameter int FLAG_LSB   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [7:0]    tm_sec,
  input  logic [7:0]    tm_min,
  input  logic [7:0]    tm_hour,
  input  logic [7:0]    tm_date,
  input  logic [7:0]    tm_month,
  input  logic [7:0]    tm_wday,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          st_rd_start,
  input  logic          st_rd_end,
  output logic [7:0]    status,
  output logic          irq
);
  localparam int FW = $clog2(FIELDS);
  localparam int SW = $clog2(NUM_ALARMS);
  localparam logic [FIELDS-1:0] RSV = 8'b1010_0000;
  localparam logic [AW-1:0] CTL_ADDR = AW'(NUM_ALARMS * FIELDS);

  logic [7:0] alm [NUM_ALARMS][FIELDS];
  logic [7:0] tnow [FIELDS];
  logic [7:0] ictl;
  logic [NUM_ALARMS-1:0] flag, snap, hit, ien;

  always_comb begin
    tnow[0] = tm_sec;
    tnow[1] = tm_min;
    tnow[2] = tm_hour;
    tnow[3] = tm_date;
    tnow[4] = tm_month;
    tnow[5] = 8'h00;
    tnow[6] = tm_wday;
    tnow[7] = 8'h00;
  end

  wire [FW-1:0] w_fld = wr_addr[FW-1:0];
  wire [SW-1:0] w_set = wr_addr[FW +: SW];
  wire          w_alm = wr_en && (wr_addr < CTL_ADDR) && !RSV[w_fld];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_ALARMS; a++)
        for (int f = 0; f < FIELDS; f++)
          alm[a][f] <= 8'h00;
      ictl <= 8'h00;
    end else begin
      if (w_alm) alm[w_set][w_fld] <= wr_data;
      if (wr_en && wr_addr == CTL_ADDR) ictl <= wr_data;
    end
  end

  always_comb begin
    for (int a = 0; a < NUM_ALARMS; a++) begin
      logic eq, any;
      eq  = 1'b1;
      any = 1'b0;
      for (int f = 0; f < FIELDS; f++) begin
        any = any | alm[a][f][7];
        if (alm[a][f][7] && alm[a][f][6:0] != tnow[f][6:0]) eq = 1'b0;
      end
      hit[a] = tick && any && eq;
    end
  end

  assign ien = ictl[FLAG_LSB +: NUM_ALARMS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= '0;
      snap <= '0;
      irq  <= 1'b0;
    end else begin
      flag <= (flag & ~(st_rd_end ? snap : '0)) | hit;
      if (st_rd_start) snap <= flag;
      irq  <= |(hit & ien & (ictl[7] ? {NUM_ALARMS{1'b1}} : ~flag));
    end
  end

  always_comb begin
    status = 8'h00;
    status[FLAG_LSB +: NUM_ALARMS] = flag;
  end

  logic unused_bits;
  assign unused_bits = ^{tm_sec[7], tm_min[7], tm_hour[7], tm_date[7], tm_month[7], tm_wday[7], ictl[4:0]};

  AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> (flag & ~$past(flag)) == '0); // R2
  AST_READ_CLEARS_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd_end && !tick) |=> (flag & $past(snap)) == '0); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag != '0)); // R8
  AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick)); // R9
  AST_KEEP_UNSNAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd_end |=> ((($past(flag) & ~$past(snap)) & ~flag) == '0)); // R7
endmodule

// File: tb/test_alarm_match_unit.sv
module test_alarm_match_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic st_rd_start = 1'b0, st_rd_end = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] tv [6];
  logic [7:0] status;
  logic irq;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_match_unit i_alarm_match_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .tm_sec(tv[0]), .tm_min(tv[1]), .tm_hour(tv[2]), .tm_date(tv[3]),
    .tm_month(tv[4]), .tm_wday(tv[5]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .st_rd_start(st_rd_start), .st_rd_end(st_rd_end),
    .status(status), .irq(irq));

  localparam logic [7:0] A0V [6] = '{8'h37, 8'h42, 8'h15, 8'h28, 8'h11, 8'h03};
  localparam logic [7:0] A1V [6] = '{8'h05, 8'h59, 8'h23, 8'h31, 8'h12, 8'h06};
  localparam logic [2:0] OFS [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] v [6]);
    for (int i = 0; i < 6; i++) tv[i] = v[i];
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd_clear();
    @(negedge clk); st_rd_start = 1'b1;
    @(negedge clk); st_rd_start = 1'b0; st_rd_end = 1'b1;
    @(negedge clk); st_rd_end = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] t [6];
    set_time(A0V);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", status, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    do_tick();
    chk("R1 no match with reset alarms", status, 8'h00);

    wr(5'h10, 8'h20);
    for (int m = 0; m < 64; m++) begin
      for (int i = 0; i < 6; i++) wr({2'b00, OFS[i]}, {m[i], A0V[i][6:0]});
      for (int f = 0; f <= 6; f++) begin
        logic exp;
        t = A0V;
        if (f < 6) t[f] = t[f] ^ 8'h01;
        set_time(t);
        do_tick();
        exp = (m != 0) && (f == 6 || !m[f]);
        chk((m == 0) ? "R4 empty mask" : "R2 R3 masked compare", status, {1'b0, 1'b0, exp, 5'b0});
        chk("R8 R9 irq first match", {7'b0, irq}, {7'b0, exp});
        rd_clear();
        chk("R6 flags cleared by read", status, 8'h00);
      end
    end

    for (int i = 0; i < 6; i++) wr({2'b00, OFS[i]}, {1'b1, A0V[i][6:0]});
    set_time(A0V);
    @(negedge clk); @(negedge clk);
    chk("R2 no flag without tick", status, 8'h00);

    do_tick();
    chk("R9 mode0 first", {7'b0, irq}, 8'h01);
    do_tick();
    chk("R9 mode0 repeat no irq", {7'b0, irq}, 8'h00);
    chk("R9 mode0 flag held", status, 8'h20);
    wr(5'h10, 8'hA0);
    do_tick();
    chk("R9 mode1 repeat irq", {7'b0, irq}, 8'h01);
    wr(5'h10, 8'h00);
    rd_clear();
    do_tick();
    chk("R8 irq disabled", {7'b0, irq}, 8'h00);
    chk("R8 flag still set", status, 8'h20);
    rd_clear();

    for (int i = 0; i < 6; i++) wr({2'b01, OFS[i]}, {1'b1, A1V[i][6:0]});
    wr(5'h10, 8'h40);
    set_time(A1V);
    do_tick();
    chk("R11 R5 alarm1 only", status, 8'h40);
    chk("R8 alarm1 irq", {7'b0, irq}, 8'h01);
    rd_clear();

    set_time(A0V);
    do_tick();
    @(negedge clk); st_rd_start = 1'b1;
    @(negedge clk); st_rd_start = 1'b0;
    set_time(A1V); tick = 1'b1;
    @(negedge clk); tick = 1'b0; st_rd_end = 1'b1;
    @(negedge clk); st_rd_end = 1'b0;
    chk("R7 R6 read keeps late flag", status, 8'h40);
    rd_clear();
    chk("R6 second read clears", status, 8'h00);

    for (int i = 0; i < 6; i++) wr({2'b00, OFS[i]}, 8'h00);
    wr(5'h00, 8'hB7);
    wr(5'h05, 8'h85);
    wr(5'h07, 8'h85);
    set_time(A0V);
    do_tick();
    chk("R10 reserved write ignored", status, 8'h20);
    rd_clear();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule